// File: doc/BRIEF.md
# Hybrid Functional Self-Test Controller

This controller runs a two-phase self-test of the ALU inside a microprogrammed datapath. In the first phase it reads stored operand pairs one at a time and starts the datapath's own division microprogram once per pair. Every ALU observation word (data plus status) that the datapath flags as valid during those runs is folded into a multiple-input signature register. The test therefore uses every microprogram cycle as a pattern, not only the final quotients.

In the second phase the controller switches a multiplexer on the ALU inputs away from the datapath buses. It then steps through a pattern memory, one precomputed stimulus word per clock. The ALU response of each of these cycles goes into the same signature. At the end the signature is compared against a golden value, and a pass or fail flag is raised and held.

The number of operand pairs, the number of stored patterns, the operand width and the stimulus width are parameters. Either phase may be configured away.

Top module: `hfb_ctrl`

## Requirements
- R1: After reset, `pass_o`, `fail_o`, `alu_sel_o` and `div_start_o` are low and `alu_in_o` follows `func_stim_i`.
- R2: A `start_i` sampled high while idle or finished loads the signature with the seed value (all ones) and clears `pass_o` and `fail_o` at that same edge.
- R3: The functional phase handles pairs j = 0..NUM_PAIRS-1 in order. For pair j, `opmem_addr_o` = j and `div_a_o`/`div_b_o` carry the addressed operands while `div_start_o` is high for exactly one cycle. The next pair is not started until `div_done_i` has been sampled high.
- R4: The signature updates as next = {sig[W-2:0],0} XOR (sig[W-1] ? POLY : 0) XOR word. It updates only on a cycle where `obs_valid_i` is high while a division is running, or on a deterministic apply cycle. Otherwise it holds, and `obs_valid_i` at any other time has no effect.
- R5: After the last pair's done pulse, NUM_PATS consecutive cycles follow with `alu_sel_o` high and `pat_addr_o` = 0, 1, 2, ... The response `obs_word_i` of each of these cycles is compacted in that same cycle.
- R6: While `alu_sel_o` is high, `alu_in_o` equals `pat_data_i`. Otherwise `alu_in_o` equals `func_stim_i`.
- R7: One cycle after the last compacted step, exactly one of `pass_o` (signature equals `golden_i`) or `fail_o` (it differs) rises.
- R8: `pass_o`/`fail_o` hold their value, whatever `obs_valid_i` does, until the next accepted start.
- R9: With NUM_PAIRS = 0 and NUM_PATS = 0 both phases are skipped. The result appears two edges after start and compares the seed against `golden_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a self-test run |
| opmem_addr_o | output | PW | Operand-pair memory address |
| opmem_a_i | input | OPW | Dividend read from operand memory |
| opmem_b_i | input | OPW | Divisor read from operand memory |
| div_a_o | output | OPW | Dividend to datapath |
| div_b_o | output | OPW | Divisor to datapath |
| div_start_o | output | 1 | One-cycle launch of the division microprogram |
| div_done_i | input | 1 | Division microprogram finished |
| func_stim_i | input | STIMW | ALU inputs from the normal datapath buses |
| pat_addr_o | output | TW | Pattern memory address |
| pat_data_i | input | STIMW | Stored deterministic stimulus |
| alu_sel_o | output | 1 | Mux select: 1 = pattern memory |
| alu_in_o | output | STIMW | Muxed ALU input word |
| obs_valid_i | input | 1 | Datapath observation strobe |
| obs_word_i | input | OBSW | ALU output data and status |
| golden_i | input | OBSW | Expected final signature |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |

## Verification
The assertions check these rules on every cycle: the launch is a single-cycle pulse, pattern addresses step by one across the apply phase, the seed is loaded after each start, the signature holds whenever no update is requested, the result flags never rise together, and a pass holds until the next start. Some properties only the directed scenarios can show. These are the exact signature over both phases in the required order, the operand values per pair, the wait for the done pulse, that strobes outside a running division are ignored, the fail path with a wrong golden value, and the skipped-phase configuration.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_NEXT, ST_DET, ST_CMP, ST_DONE
  } hfb_state_e;

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hfb_misr.sv
module hfb_misr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h6801,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         upd_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q, fb;

  assign fb = sig_q[W-1] ? POLY : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sig_q <= SEED;
    else if (clr_i) sig_q <= SEED;
    else if (upd_i) sig_q <= {sig_q[W-2:0], 1'b0} ^ fb ^ data_i;
  end

  assign sig_o = sig_q;

  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sig_o == SEED);
  // R4
  sig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(sig_o));
endmodule

// File: rtl/hfb_stim_mux.sv
module hfb_stim_mux #(
  parameter int STIMW = 16
) (
  input  logic             sel_i,
  input  logic [STIMW-1:0] func_i,
  input  logic [STIMW-1:0] pat_i,
  output logic [STIMW-1:0] alu_in_o
);
  for (genvar b = 0; b < STIMW; b++) begin : g_bit
    assign alu_in_o[b] = sel_i ? pat_i[b] : func_i[b];
  end
endmodule

// File: rtl/hfb_seq.sv
module hfb_seq
  import hfb_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_PATS  = 5,
  localparam int PW = idx_w(NUM_PAIRS),
  localparam int TW = idx_w(NUM_PATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          div_done_i,
  input  logic          obs_valid_i,
  input  logic          sig_match_i,
  output logic [PW-1:0] pair_idx_o,
  output logic [TW-1:0] pat_idx_o,
  output logic          div_start_o,
  output logic          det_apply_o,
  output logic          misr_clr_o,
  output logic          misr_upd_o,
  output logic          pass_o,
  output logic          fail_o
);
  localparam int LAST_PAIR = (NUM_PAIRS > 0) ? NUM_PAIRS - 1 : 0;
  localparam int LAST_PAT  = (NUM_PATS  > 0) ? NUM_PATS  - 1 : 0;

  hfb_state_e st_q, st_d;
  logic [PW-1:0] pair_q;
  logic [TW-1:0] pat_q;
  logic start_ok, last_pair, last_pat, pass_q, fail_q;

  assign start_ok  = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign last_pair = pair_q == PW'(LAST_PAIR);
  assign last_pat  = pat_q == TW'(LAST_PAT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_DONE:
        if (start_i) begin
          if (NUM_PAIRS > 0)     st_d = ST_LOAD;
          else if (NUM_PATS > 0) st_d = ST_DET;
          else                   st_d = ST_CMP;
        end
      ST_LOAD: st_d = ST_RUN;
      ST_RUN:  if (div_done_i) st_d = ST_NEXT;
      ST_NEXT: begin
        if (!last_pair)        st_d = ST_LOAD;
        else if (NUM_PATS > 0) st_d = ST_DET;
        else                   st_d = ST_CMP;
      end
      ST_DET:  if (last_pat) st_d = ST_CMP;
      ST_CMP:  st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pair_q <= '0;
      pat_q  <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_ok) begin
        pair_q <= '0;
        pat_q  <= '0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else begin
        if (st_q == ST_NEXT && !last_pair) pair_q <= pair_q + PW'(1);
        if (st_q == ST_DET && !last_pat)   pat_q  <= pat_q + TW'(1);
        if (st_q == ST_CMP) begin
          pass_q <= sig_match_i;
          fail_q <= !sig_match_i;
        end
      end
    end
  end

  assign pair_idx_o  = pair_q;
  assign pat_idx_o   = pat_q;
  assign div_start_o = st_q == ST_LOAD;
  assign det_apply_o = st_q == ST_DET;
  assign misr_clr_o  = start_ok;
  // strobes outside a running division are ignored
  assign misr_upd_o  = det_apply_o || (st_q == ST_RUN && obs_valid_i);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start_o |=> !div_start_o);
  // R5
  det_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_apply_o && $past(det_apply_o)) |-> pat_idx_o == $past(pat_idx_o) + TW'(1));
  // R7
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o && !start_i) |=> pass_o);
endmodule

// File: rtl/hfb_ctrl.sv
module hfb_ctrl
  import hfb_pkg::*;
#(
  parameter int             NUM_PAIRS = 3,
  parameter int             NUM_PATS  = 5,
  parameter int             OPW       = 8,
  parameter int             STIMW     = 16,
  parameter int             OBSW      = 16,
  parameter logic [OBSW-1:0] POLY     = 16'h6801,
  parameter logic [OBSW-1:0] SEED     = '1,
  localparam int PW = idx_w(NUM_PAIRS),
  localparam int TW = idx_w(NUM_PATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [PW-1:0]    opmem_addr_o,
  input  logic [OPW-1:0]   opmem_a_i,
  input  logic [OPW-1:0]   opmem_b_i,
  output logic [OPW-1:0]   div_a_o,
  output logic [OPW-1:0]   div_b_o,
  output logic             div_start_o,
  input  logic             div_done_i,
  input  logic [STIMW-1:0] func_stim_i,
  output logic [TW-1:0]    pat_addr_o,
  input  logic [STIMW-1:0] pat_data_i,
  output logic             alu_sel_o,
  output logic [STIMW-1:0] alu_in_o,
  input  logic             obs_valid_i,
  input  logic [OBSW-1:0]  obs_word_i,
  input  logic [OBSW-1:0]  golden_i,
  output logic             pass_o,
  output logic             fail_o
);
  logic misr_clr, misr_upd, det_apply;
  logic [OBSW-1:0] sig;

  hfb_seq #(.NUM_PAIRS(NUM_PAIRS), .NUM_PATS(NUM_PATS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .div_done_i  (div_done_i),
    .obs_valid_i (obs_valid_i),
    .sig_match_i (sig == golden_i),
    .pair_idx_o  (opmem_addr_o),
    .pat_idx_o   (pat_addr_o),
    .div_start_o (div_start_o),
    .det_apply_o (det_apply),
    .misr_clr_o  (misr_clr),
    .misr_upd_o  (misr_upd),
    .pass_o      (pass_o),
    .fail_o      (fail_o)
  );

  hfb_misr #(.W(OBSW), .POLY(POLY), .SEED(SEED)) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (misr_clr),
    .upd_i  (misr_upd),
    .data_i (obs_word_i),
    .sig_o  (sig)
  );

  hfb_stim_mux #(.STIMW(STIMW)) u_mux (
    .sel_i    (det_apply),
    .func_i   (func_stim_i),
    .pat_i    (pat_data_i),
    .alu_in_o (alu_in_o)
  );

  assign alu_sel_o = det_apply;
  assign div_a_o   = opmem_a_i;
  assign div_b_o   = opmem_b_i;
endmodule

// File: tb/hfb_ctrl_test.sv
`timescale 1ns/1ps
module hfb_ctrl_test;
  localparam int K = 3, D = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done = 1'b0, obs_valid = 1'b0;
  logic [15:0] fword = '0, golden = '0, func_stim = 16'hC3A5;
  logic [1:0] op_addr;
  logic [7:0] op_a, op_b, div_a, div_b;
  logic [2:0] pat_addr;
  logic [15:0] pat_data, alu_in, obs_word;
  logic div_start, alu_sel, pass, fail;
  logic pz, fz, sz, dz, oz;
  logic [15:0] az;
  logic [7:0] da_z, db_z;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  function automatic [7:0] opa(input int j); return 8'(8'h31 + j * 8'h17); endfunction
  function automatic [7:0] opb(input int j); return 8'(8'h9C ^ (j * 8'h25)); endfunction
  function automatic [15:0] pat(input int i); return 16'(i * 16'h03B5) ^ 16'hA5C3; endfunction
  function automatic [15:0] alu_g(input [15:0] x); return {x[7:0], x[15:8]} ^ 16'h1234; endfunction
  function automatic [15:0] fw(input int j, input int c);
    return {opa(j), opb(j)} + 16'(c * 16'h0101);
  endfunction
  function automatic [15:0] mstep(input [15:0] m, input [15:0] w);
    return {m[14:0], 1'b0} ^ (m[15] ? 16'h6801 : 16'h0000) ^ w;
  endfunction

  assign op_a     = opa(int'(op_addr));
  assign op_b     = opb(int'(op_addr));
  assign pat_data = pat(int'(pat_addr));
  assign obs_word = alu_sel ? alu_g(alu_in) : fword;

  hfb_ctrl #(.NUM_PAIRS(K), .NUM_PATS(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .opmem_addr_o(op_addr), .opmem_a_i(op_a), .opmem_b_i(op_b),
    .div_a_o(div_a), .div_b_o(div_b), .div_start_o(div_start), .div_done_i(done),
    .func_stim_i(func_stim), .pat_addr_o(pat_addr), .pat_data_i(pat_data),
    .alu_sel_o(alu_sel), .alu_in_o(alu_in), .obs_valid_i(obs_valid),
    .obs_word_i(obs_word), .golden_i(golden), .pass_o(pass), .fail_o(fail)
  );

  logic za_addr, zp_addr;
  hfb_ctrl #(.NUM_PAIRS(0), .NUM_PATS(0)) uut_z (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .opmem_addr_o(za_addr), .opmem_a_i(8'h00), .opmem_b_i(8'h00),
    .div_a_o(da_z), .div_b_o(db_z), .div_start_o(dz), .div_done_i(1'b0),
    .func_stim_i(16'h0F0F), .pat_addr_o(zp_addr), .pat_data_i(16'h0000),
    .alu_sel_o(sz), .alu_in_o(az), .obs_valid_i(oz),
    .obs_word_i(16'h0000), .golden_i(16'hFFFF), .pass_o(pz), .fail_o(fz)
  );
  assign oz = obs_valid;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [15:0] expected_sig();
    logic [15:0] m = 16'hFFFF;
    for (int j = 0; j < K; j++)
      for (int c = 0; c < 2 + j; c++) m = mstep(m, fw(j, c));
    for (int i = 0; i < D; i++) m = mstep(m, alu_g(pat(i)));
    return m;
  endfunction

  task automatic divider_model();
    for (int j = 0; j < K; j++) begin
      int n = 0;
      while (!div_start && n < 100) begin @(negedge clk); n++; end
      // R3
      chk(op_addr == 2'(j) && div_a == opa(j) && div_b == opb(j), "R3 operands",
          {op_addr, div_a, div_b}, {2'(j), opa(j), opb(j)});
      @(negedge clk);
      begin
        bit again = 1'b0;
        repeat (3) begin @(negedge clk); if (div_start) again = 1'b1; end
        // R3 waits for done
        chk(!again, "R3 no advance before done", again, 0);
      end
      for (int c = 0; c < 2 + j; c++) begin
        obs_valid = 1'b1; fword = fw(j, c);
        @(negedge clk);
        obs_valid = 1'b0; fword = 16'hDEAD;
        @(negedge clk);
      end
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      // R4: strobes outside a running division must not count
      if (j == K - 1) begin obs_valid = 1'b1; fword = 16'hBEEF; end
    end
  endtask

  task automatic det_monitor();
    int cnt = 0, guard = 0;
    bit mux_bad = 1'b0;
    while (!(pass || fail) && guard < 500) begin
      @(negedge clk);
      guard++;
      if (alu_sel) begin
        // R5, R6
        chk(pat_addr == 3'(cnt) && alu_in == pat(cnt), "R5 pattern step",
            {pat_addr, alu_in}, {3'(cnt), pat(cnt)});
        cnt++;
      end else if (alu_in != func_stim) mux_bad = 1'b1;
    end
    chk(cnt == D, "R5 apply count", cnt, D);
    chk(!mux_bad, "R6 functional passthrough", mux_bad, 0);
  endtask

  task automatic run_test(input bit good);
    logic [15:0] e = expected_sig();
    golden = good ? e : ~e;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2
    chk(!pass && !fail, "R2 result cleared on start", {pass, fail}, 0);
    fork
      divider_model();
      det_monitor();
    join
    // R7
    chk(pass == good && fail == !good, "R7 result", {pass, fail}, {good, !good});
  endtask

  task automatic t_reset();
    // R1
    chk(!pass && !fail && !alu_sel && !div_start, "R1 reset outputs",
        {pass, fail, alu_sel, div_start}, 0);
    chk(alu_in == func_stim, "R1 mux after reset", alu_in, func_stim);
  endtask

  task automatic t_skip();
    // R9: both phases skipped, two edges after start
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!pz && !fz, "R9 not yet decided", {pz, fz}, 0);
    @(negedge clk);
    chk(pz && !fz && !sz && !dz, "R9 seed compare passes", {pz, fz, sz, dz}, 4'b1000);
  endtask

  task automatic t_hold();
    repeat (5) begin
      @(negedge clk); obs_valid = ~obs_valid; fword = fword + 16'h1111;
    end
    // R8
    chk(pass && !fail, "R8 result held", {pass, fail}, 2'b10);
    obs_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_skip();
    run_test(1'b1);
    t_hold();
    run_test(1'b0);
    obs_valid = 1'b0;
    run_test(1'b1);
    obs_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule